// File: doc/BRIEF.md
# Power-cycle restore sequencer

This controller sits beside a user register that has a persistent shadow copy. When the synchronised supply-good flag rises, it fetches the whole shadow word. It then steers that word onto the register's internal data path in place of the external inputs and fires one internally generated clock pulse, which loads the saved state back into the register. User writes stay blocked for a fixed hold-off interval after power-good. After that the register belongs to the user again, and a one-cycle status pulse marks the handover.

When the supply flag drops, the sequencer blocks new user captures and new shadow updates at once. It then waits in a drain state until the write-back engine reports that the write in flight has finished. Only after that can a new restore start. If power fails while the shadow is still being read or while the restored word is being loaded, the restore is abandoned. The sequencer returns to idle without touching the shadow.

All intervals are cycle counts set by parameters. Threshold detection of the supply itself happens outside this block.

Top module: `pwr_restore_seq`

## Requirements
- R1: Out of reset the sequencer is idle: `shd_rd_req`, `inj_sel`, `inj_clk` and `restore_done` are 0, and `user_wr_block` and `upd_block` are 1.
- R2: In the first cycle after an edge that samples `pwr_ok`=1 in idle, `shd_rd_req` is 1 and stays 1 (with `inj_sel` 0 and both blocks 1) until an edge samples `shd_rd_done`=1. After that edge `shd_rd_req` is 0 and `inj_sel` is 1.
- R3: `inj_data` takes the value on `shd_rdata` at the edge that samples `shd_rd_done`=1. It holds that value while `shd_rdata` changes afterwards.
- R4: `inj_clk` rises one edge after `inj_sel` rises, stays high for exactly PULSE_CYC cycles and then stays low. There is one pulse per restore, and it only occurs while `inj_sel` is 1.
- R5: If `shd_rd_done` is sampled no later than RES_CYC−PULSE_CYC−1 edges after the edge that raised `shd_rd_req`, then `inj_clk` is 0 again by RES_CYC edges after that edge.
- R6: `user_wr_block` and `upd_block` both fall at the same edge. That edge is the later of two: HOLD_CYC edges after the edge that raised `shd_rd_req`, or two edges after the pulse's last high cycle. At that same edge `inj_sel` falls.
- R7: `restore_done` is 1 for exactly the first cycle in which the blocks are 0, and 0 otherwise.
- R8: If `pwr_ok` is sampled 0 while running, both blocks are 1 after that edge. The sequencer then raises no `shd_rd_req`, even if `pwr_ok` returns, until an edge samples `wb_busy`=0. It is idle after that edge and starts a new read one edge later if `pwr_ok` is 1.
- R9: If `pwr_ok` is sampled 0 during the read or load phase, then after that edge `shd_rd_req`, `inj_sel` and `inj_clk` are 0, both blocks stay 1, and `restore_done` does not pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Synchronised supply-above-threshold flag |
| shd_rdata | input | WIDTH | Word read from the shadow store |
| shd_rd_done | input | 1 | Shadow read complete, `shd_rdata` valid |
| wb_busy | input | 1 | Write-back engine has a shadow write in progress |
| shd_rd_req | output | 1 | Request to read the whole shadow store |
| inj_sel | output | 1 | Select restored word instead of external inputs |
| inj_data | output | WIDTH | Restored word for the register's internal data path |
| inj_clk | output | 1 | Internally generated load pulse for the user register |
| user_wr_block | output | 1 | Blocks user captures into the register |
| upd_block | output | 1 | Blocks new shadow updates |
| restore_done | output | 1 | One-cycle pulse when normal operation begins |

## Verification
A wrong internal state shows up at the block edge within one cycle. A phase entered too early or too late appears as `shd_rd_req`, `inj_sel` or the block flags switching at the wrong edge. A bad pulse counter shows as an `inj_clk` high time other than PULSE_CYC, or as a second pulse. A hold-off counter that is off by one moves the edge where both blocks fall and `restore_done` fires. A missing drain or abort path shows as a read request raised while the write-back engine is still busy, or a select left high after power loss. The bench predicts each of these edges from the request edge and compares them cycle by cycle.

// File: rtl/pwr_restore_pkg.sv
package pwr_restore_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_READ  = 3'd1,
        ST_LOAD  = 3'd2,
        ST_RUN   = 3'd3,
        ST_DRAIN = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       done;
    } seq_ctl_t;

endpackage

// File: rtl/rs_elapsed.sv
// Saturating cycle counter, cleared while idle.
module rs_elapsed #(
    parameter int unsigned MAXV = 375,
    localparam int unsigned CW  = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LIM = CW'(MAXV);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)              cnt_d = '0;
        else if (cnt_q < LIM) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rs_pulse.sv
// One pulse of LEN cycles per arm period; starts the cycle after arm rises.
module rs_pulse #(
    parameter int unsigned LEN = 4,
    localparam int unsigned CW = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic pulse,
    output logic spent
);
    localparam logic [CW-1:0] LEN_V = CW'(LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fired;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (!arm) begin
            pg_d.cnt   = '0;
            pg_d.fired = 1'b0;
        end else if (!pg_q.fired) begin
            pg_d.cnt   = LEN_V;
            pg_d.fired = 1'b1;
        end else if (pg_q.cnt != '0) begin
            pg_d.cnt = pg_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign pulse = (pg_q.cnt != '0);
    assign spent = pg_q.fired && (pg_q.cnt == '0);
endmodule

// File: rtl/rs_hold_reg.sv
// Holds the shadow word captured at read completion.
module rs_hold_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) val_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign dout = val_q;
endmodule

// File: rtl/pwr_restore_seq.sv
module pwr_restore_seq
    import pwr_restore_pkg::*;
#(
    parameter int unsigned WIDTH     = 8,
    parameter int unsigned RES_CYC   = 250,
    parameter int unsigned HOLD_CYC  = 375,
    parameter int unsigned PULSE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok,
    input  logic [WIDTH-1:0] shd_rdata,
    input  logic             shd_rd_done,
    input  logic             wb_busy,
    output logic             shd_rd_req,
    output logic             inj_sel,
    output logic [WIDTH-1:0] inj_data,
    output logic             inj_clk,
    output logic             user_wr_block,
    output logic             upd_block,
    output logic             restore_done
);
    localparam int unsigned EW = $clog2(HOLD_CYC + 1);
    localparam logic [EW-1:0] HOLD_LIM = EW'(HOLD_CYC - 1);
    // RES_CYC is the budget the read latency must respect; it sizes nothing here.
    localparam int unsigned RES_SLACK = (RES_CYC > PULSE_CYC + 1) ? RES_CYC - PULSE_CYC - 1 : 0;

    seq_ctl_t      ctl_d, ctl_q;
    logic [EW-1:0] elapsed;
    logic          pulse_raw, pulse_spent;
    logic          capture, hold_met;

    rs_elapsed #(.MAXV(HOLD_CYC)) u_elapsed (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((ctl_q.st == ST_OFF) || (ctl_q.st == ST_DRAIN)),
        .cnt   (elapsed)
    );

    rs_pulse #(.LEN(PULSE_CYC)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (ctl_q.st == ST_LOAD),
        .pulse (pulse_raw),
        .spent (pulse_spent)
    );

    rs_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (capture),
        .din   (shd_rdata),
        .dout  (inj_data)
    );

    assign hold_met = (elapsed >= HOLD_LIM);
    assign capture  = (ctl_q.st == ST_READ) && pwr_ok && shd_rd_done;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_OFF: begin
                if (pwr_ok) ctl_d.st = ST_READ;
            end
            ST_READ: begin
                if (!pwr_ok)          ctl_d.st = ST_OFF;
                else if (shd_rd_done) ctl_d.st = ST_LOAD;
            end
            ST_LOAD: begin
                if (!pwr_ok) begin
                    ctl_d.st = ST_OFF;
                end else if (pulse_spent && hold_met) begin
                    ctl_d.st   = ST_RUN;
                    ctl_d.done = 1'b1;
                end
            end
            ST_RUN: begin
                if (!pwr_ok) ctl_d.st = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!wb_busy) ctl_d.st = ST_OFF;
            end
            default: ctl_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_OFF;
            ctl_q.done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign shd_rd_req    = (ctl_q.st == ST_READ);
    assign inj_sel       = (ctl_q.st == ST_LOAD);
    assign inj_clk       = pulse_raw && inj_sel;
    assign user_wr_block = (ctl_q.st != ST_RUN);
    assign upd_block     = (ctl_q.st != ST_RUN);
    assign restore_done  = ctl_q.done;
endmodule

// File: rtl/pwr_restore_seq_chk.sv
module pwr_restore_seq_chk #(
    parameter int unsigned HOLD_CYC = 375
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok,
    input logic shd_rd_req,
    input logic inj_sel,
    input logic inj_clk,
    input logic user_wr_block,
    input logic upd_block,
    input logic restore_done
);
    int unsigned since_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_req <= 0;
        else if (user_wr_block && !shd_rd_req && !inj_sel) since_req <= 0;
        else if (since_req < HOLD_CYC) since_req <= since_req + 1;
    end

    AST_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        shd_rd_req |-> (!inj_sel && user_wr_block && upd_block)); // R2
    AST_CLK_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inj_clk) |-> $past(inj_sel)); // R4
    AST_HOLDOFF_MET: assert property (@(posedge clk) disable iff (!rst_n)
        !user_wr_block |-> (since_req >= HOLD_CYC)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_done |=> !restore_done); // R7
    AST_DONE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        restore_done |-> (!user_wr_block && $past(user_wr_block))); // R7
    AST_LOSS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (user_wr_block && upd_block)); // R8
    AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ((shd_rd_req || inj_sel) && !pwr_ok) |=> (!shd_rd_req && !inj_sel && !inj_clk && !restore_done)); // R9
endmodule

bind pwr_restore_seq pwr_restore_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_ok        (pwr_ok),
    .shd_rd_req    (shd_rd_req),
    .inj_sel       (inj_sel),
    .inj_clk       (inj_clk),
    .user_wr_block (user_wr_block),
    .upd_block     (upd_block),
    .restore_done  (restore_done)
);

// File: tb/sim_pwr_restore_seq.sv
module sim_pwr_restore_seq;
    localparam int W    = 8;
    localparam int RES  = 250;
    localparam int HOLD = 375;
    localparam int P    = 4;

    // outs = {req, sel, clk, uwb, ub, done}
    localparam logic [5:0] V_OFF   = 6'b000110;
    localparam logic [5:0] V_READ  = 6'b100110;
    localparam logic [5:0] V_LOAD  = 6'b010110;
    localparam logic [5:0] V_LOADP = 6'b011110;
    localparam logic [5:0] V_RUN   = 6'b000000;
    localparam logic [5:0] V_DONE  = 6'b000001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b0;
    logic [W-1:0] shd_rdata = '0;
    logic shd_rd_done = 1'b0;
    logic wb_busy = 1'b0;
    logic shd_rd_req, inj_sel, inj_clk, user_wr_block, upd_block, restore_done;
    logic [W-1:0] inj_data;

    always #2 clk = ~clk;

    pwr_restore_seq #(.WIDTH(W), .RES_CYC(RES), .HOLD_CYC(HOLD), .PULSE_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .shd_rdata(shd_rdata),
        .shd_rd_done(shd_rd_done), .wb_busy(wb_busy), .shd_rd_req(shd_rd_req),
        .inj_sel(inj_sel), .inj_data(inj_data), .inj_clk(inj_clk),
        .user_wr_block(user_wr_block), .upd_block(upd_block), .restore_done(restore_done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [5:0] o;
        bit         chk_d;
        logic [7:0] d;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int tests = 0;
    int fails = 0;

    task automatic push(input int at, input logic [5:0] o, input string tag);
        exp_t e;
        e.at = at; e.o = o; e.chk_d = 1'b0; e.d = '0; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic pushd(input int at, input logic [5:0] o, input logic [7:0] d, input string tag);
        exp_t e;
        e.at = at; e.o = o; e.chk_d = 1'b1; e.d = d; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor: compares at the negedge following edge number 'at'
    always @(negedge clk) begin
        logic [5:0] act;
        act = {shd_rd_req, inj_sel, inj_clk, user_wr_block, upd_block, restore_done};
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            tests++;
            if (e.at < cyc) begin
                fails++;
                $display("FAIL %s: check for cycle %0d missed (now %0d)", e.tag, e.at, cyc);
            end else if (act !== e.o || (e.chk_d && inj_data !== e.d)) begin
                fails++;
                $display("FAIL %s: cycle %0d outs=%b data=%h expected outs=%b data=%h",
                         e.tag, cyc, act, inj_data, e.o, e.d);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int b, e0, ea;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        b = cyc;
        push(b + 2, V_OFF, "R1");
        wait_to(b + 3);

        // Normal restore, read latency 5
        b = cyc; e0 = b + 1; ea = e0 + 5;
        push(e0, V_READ, "R2");
        push(ea - 1, V_READ, "R2");
        pushd(ea, V_LOAD, 8'hA5, "R2");
        pushd(ea + 1, V_LOADP, 8'hA5, "R4");
        push(ea + P, V_LOADP, "R4");
        pushd(ea + P + 1, V_LOAD, 8'hA5, "R3");
        push(ea + P + 2, V_LOAD, "R4");
        push(e0 + RES, V_LOAD, "R5");
        push(e0 + HOLD - 1, V_LOAD, "R6");
        push(e0 + HOLD, V_DONE, "R7");
        pushd(e0 + HOLD + 1, V_RUN, 8'hA5, "R7");
        pwr_ok = 1'b1;
        wait_to(ea - 1);
        shd_rdata = 8'hA5; shd_rd_done = 1'b1;
        wait_to(ea);
        shd_rd_done = 1'b0; shd_rdata = 8'h3C;
        wait_to(e0 + HOLD + 3);

        // R8: power loss while running, write-back busy
        b = cyc; e0 = b + 10; ea = e0 + (RES - P - 1);
        push(b + 1, V_OFF, "R8");
        push(b + 6, V_OFF, "R8");
        push(b + 9, V_OFF, "R8");
        push(e0, V_READ, "R8");
        push(ea - 1, V_READ, "R5");
        pushd(ea, V_LOAD, 8'h5A, "R3");
        push(e0 + RES - 1, V_LOADP, "R5");
        push(e0 + RES, V_LOAD, "R5");
        pushd(e0 + HOLD, V_DONE, 8'h5A, "R6");
        pwr_ok = 1'b0; wb_busy = 1'b1;
        wait_to(b + 3);
        pwr_ok = 1'b1;
        wait_to(b + 8);
        wb_busy = 1'b0;
        wait_to(ea - 1);
        shd_rdata = 8'h5A; shd_rd_done = 1'b1;
        wait_to(ea);
        shd_rd_done = 1'b0; shd_rdata = 8'hFF;
        wait_to(e0 + HOLD + 2);

        // R9: abort during read
        b = cyc;
        push(b + 2, V_OFF, "R8");
        push(b + 5, V_READ, "R9");
        push(b + 7, V_OFF, "R9");
        push(b + 9, V_OFF, "R9");
        pwr_ok = 1'b0;
        wait_to(b + 3);
        pwr_ok = 1'b1;
        wait_to(b + 6);
        pwr_ok = 1'b0;
        wait_to(b + 10);

        // R9: abort during load while pulse is high
        b = cyc; e0 = b + 1; ea = e0 + 2;
        pushd(ea + 2, V_LOADP, 8'h81, "R9");
        push(ea + 3, V_OFF, "R9");
        push(ea + 8, V_OFF, "R9");
        pwr_ok = 1'b1;
        wait_to(ea - 1);
        shd_rdata = 8'h81; shd_rd_done = 1'b1;
        wait_to(ea);
        shd_rd_done = 1'b0;
        wait_to(ea + 2);
        pwr_ok = 1'b0;
        wait_to(ea + 10);

        // R6: slow read, pulse end dominates hold-off
        b = cyc; e0 = b + 1; ea = e0 + HOLD;
        push(e0 + HOLD - 1, V_READ, "R6");
        push(ea + P + 1, V_LOAD, "R6");
        pushd(ea + P + 2, V_DONE, 8'hC3, "R6");
        push(ea + P + 3, V_RUN, "R7");
        pwr_ok = 1'b1;
        wait_to(ea - 1);
        shd_rdata = 8'hC3; shd_rd_done = 1'b1;
        wait_to(ea);
        shd_rd_done = 1'b0;
        wait_to(ea + P + 5);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule